// File: doc/BRIEF.md
# Two-Wire Frequency Control Register Slave

This block is a two-wire serial slave that holds the frequency-setting words of an on-chip synthesizer. A host writes a register index and then data bytes; the slave keeps a 10-bit oscillator tuning word and a 5-bit range word and drives both as parallel outputs to the clock path. The frequency that follows is a range minimum plus the tuning word times the step size, so the outputs must never show a partly written tuning word.

SCL and SDA are oversampled by the system clock through synchronizers, and the slave pulls SDA low through an open-drain enable. A write carries the device address, a register index and data bytes. A read is normally a write of the register index followed by a repeated START and a read address. Power-up values come from parameters.

Top module: `twfreq_regif`

## Requirements
- R1: After reset `ctrl_word` equals parameter CTRL_INIT (default 500), `range_word` equals RANGE_INIT (default 9), and `sda_oe` is 0.
- R2: The slave acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 7'h58, so 8'hB0 writes and 8'hB1 reads). Any other address is not acknowledged and the rest of that transaction changes no output.
- R3: Register index 8'h08 (tuning word) and 8'h0E (range word) are acknowledged. Any other index is not acknowledged, and the data bytes that follow are neither acknowledged nor stored.
- R4: A tuning-word write takes two data bytes: byte 0 gives word bits 9..2, bits 7..6 of byte 1 give word bits 1..0, and bits 5..0 of byte 1 are ignored. Every data byte to a known register is acknowledged.
- R5: `ctrl_word` changes only once the second tuning byte has been received. A transaction that ends or restarts after the first byte leaves it unchanged.
- R6: A range write takes one byte. Its bits 4..0 become `range_word`, and bits 7..5 are ignored.
- R7: Reading index 8'h08 returns word[9:2], then {word[1:0], 6'b0}. Reading 8'h0E returns {3'b0, range}. Bytes past a register's width read as 8'h00. Reads leave the outputs unchanged.
- R8: Write bytes past a register's width are acknowledged and discarded.
- R9: A START or a repeated START at any point restarts the address phase, and byte numbering restarts at byte 0 of the current register index. The index is kept across transactions, so a read with no index write uses the last one. SDA is sampled on SCL rising and driven only while SCL is low.
- R10: When the host does not acknowledge a read byte, the slave releases SDA and waits for a START. After a STOP, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| ctrl_word | output | 10 | Oscillator tuning word |
| range_word | output | 5 | Oscillator range word |

## Verification
A wrong byte counter or staging register shows at the parallel outputs. It appears either as a tuning word that changes after one byte or as bits placed at the wrong positions, and it is visible one clock after the acknowledge edge of the byte concerned. A wrong state-machine step shows on SDA within one bit time: an acknowledge that goes missing or is added, or a read byte shifted by one position. Bad pointer or byte-numbering state is seen in the first read byte of the next transaction.

// File: rtl/twfreq_pkg.sv
package twfreq_pkg;
  localparam int CTRL_W  = 10;
  localparam int RANGE_W = 5;
  localparam int BYTE_W  = 8;
  localparam int LO_BITS = CTRL_W - BYTE_W;

  localparam logic [7:0] IDX_CTRL  = 8'h08;
  localparam logic [7:0] IDX_RANGE = 8'h0E;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INDEX,
    ST_INDEX_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } tw_state_e;

  function automatic logic index_known(input logic [7:0] idx);
    return (idx == IDX_CTRL) || (idx == IDX_RANGE);
  endfunction

  function automatic logic [CTRL_W-1:0] join_ctrl(input logic [7:0] upper,
                                                  input logic [7:0] lower);
    return {upper, lower[7 -: LO_BITS]};
  endfunction

  function automatic logic [7:0] fetch_byte(input logic [7:0] idx,
                                            input logic [1:0] pos,
                                            input logic [CTRL_W-1:0] ctrl,
                                            input logic [RANGE_W-1:0] rng);
    logic [7:0] b;
    b = 8'h00;
    if (idx == IDX_CTRL) begin
      if (pos == 2'd0)      b = ctrl[CTRL_W-1 -: BYTE_W];
      else if (pos == 2'd1) b = {ctrl[LO_BITS-1:0], {(BYTE_W-LO_BITS){1'b0}}};
    end else if (idx == IDX_RANGE) begin
      if (pos == 2'd0) b = {{(BYTE_W-RANGE_W){1'b0}}, rng};
    end
    return b;
  endfunction
endpackage

// File: rtl/twfreq_sync.sv
module twfreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] chain [STAGES];
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      chain[0] <= {scl_i, sda_i};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      scl_p <= chain[STAGES-1][1];
      sda_p <= chain[STAGES-1][0];
    end
  end

  assign scl_s    = chain[STAGES-1][1];
  assign sda_s    = chain[STAGES-1][0];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twfreq_engine.sv
module twfreq_engine
  import twfreq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h58
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       ptr_wr,
  output logic [7:0] ptr_val,
  output logic       data_wr,
  output logic [7:0] data_val,
  output logic [1:0] byte_pos,
  output logic       byte_done
);
  tw_state_e  state;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sr;
  logic [7:0] tx_sr;
  logic       rd_mode;
  logic       host_ack;
  logic       oe_q;
  logic [1:0] pos_q;
  logic       rx_phase;

  assign rx_phase  = (state == ST_ADDR) || (state == ST_INDEX) || (state == ST_WDATA);
  assign byte_done = rx_phase && scl_fall && (bit_cnt == 4'd8);
  assign ptr_wr    = byte_done && (state == ST_INDEX) && index_known(rx_sr);
  assign ptr_val   = rx_sr;
  assign data_wr   = byte_done && (state == ST_WDATA);
  assign data_val  = rx_sr;
  assign byte_pos  = pos_q;
  assign sda_oe    = oe_q;

  function automatic logic [1:0] pos_next(input logic [1:0] p);
    return (p == 2'd3) ? p : p + 2'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      oe_q     <= 1'b0;
      pos_q    <= '0;
    end else if (start_ev) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
      pos_q   <= '0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_INDEX, ST_WDATA: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            rx_sr   <= {rx_sr[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (state == ST_ADDR) begin
              if (rx_sr[7:1] == DEV_ADDR) begin
                rd_mode <= rx_sr[0];
                oe_q    <= 1'b1;
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_INDEX) begin
              if (index_known(rx_sr)) begin
                oe_q  <= 1'b1;
                pos_q <= '0;
                state <= ST_INDEX_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              oe_q  <= 1'b1;
              pos_q <= pos_next(pos_q);
              state <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              tx_sr <= rd_data;
              oe_q  <= ~rd_data[7];
              state <= ST_RDATA;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_INDEX;
            end
          end
        end
        ST_INDEX_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              oe_q  <= 1'b0;
              pos_q <= pos_next(pos_q);
              state <= ST_RDATA_ACK;
            end else begin
              tx_sr <= {tx_sr[6:0], 1'b0};
              oe_q  <= ~tx_sr[6];
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (host_ack) begin
              tx_sr <= rd_data;
              oe_q  <= ~rd_data[7];
              state <= ST_RDATA;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          oe_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/twfreq_regs.sv
module twfreq_regs
  import twfreq_pkg::*;
#(
  parameter logic [CTRL_W-1:0]  CTRL_INIT  = 10'd500,
  parameter logic [RANGE_W-1:0] RANGE_INIT = 5'd9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ptr_wr,
  input  logic [7:0]         ptr_val,
  input  logic               data_wr,
  input  logic [7:0]         data_val,
  input  logic [1:0]         byte_pos,
  output logic [7:0]         rd_data,
  output logic               ctrl_commit,
  output logic               range_commit,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic [RANGE_W-1:0] range_q
);
  logic [7:0] ptr_q;
  logic [7:0] stage_q;
  logic       stage_wr;

  assign stage_wr     = data_wr && (ptr_q == IDX_CTRL)  && (byte_pos == 2'd0);
  assign ctrl_commit  = data_wr && (ptr_q == IDX_CTRL)  && (byte_pos == 2'd1);
  assign range_commit = data_wr && (ptr_q == IDX_RANGE) && (byte_pos == 2'd0);
  assign rd_data      = fetch_byte(ptr_q, byte_pos, ctrl_q, range_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= IDX_CTRL;
      stage_q <= '0;
      ctrl_q  <= CTRL_INIT;
      range_q <= RANGE_INIT;
    end else begin
      if (ptr_wr)       ptr_q   <= ptr_val;
      if (stage_wr)     stage_q <= data_val;
      if (ctrl_commit)  ctrl_q  <= join_ctrl(stage_q, data_val);
      if (range_commit) range_q <= data_val[RANGE_W-1:0];
    end
  end
endmodule

// File: rtl/twfreq_regif.sv
module twfreq_regif
  import twfreq_pkg::*;
#(
  parameter logic [6:0]         DEV_ADDR    = 7'h58,
  parameter logic [CTRL_W-1:0]  CTRL_INIT   = 10'd500,
  parameter logic [RANGE_W-1:0] RANGE_INIT  = 5'd9,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [CTRL_W-1:0]  ctrl_word,
  output logic [RANGE_W-1:0] range_word
);
  logic       scl_s, sda_s;
  logic       scl_rise_ev, scl_fall_ev, start_ev, stop_ev;
  logic       ptr_wr, data_wr, byte_done_ev;
  logic [7:0] ptr_val, data_val, rd_data;
  logic [1:0] byte_pos;
  logic       ctrl_commit, range_commit;

  twfreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise_ev),
    .scl_fall (scl_fall_ev),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  twfreq_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise_ev),
    .scl_fall  (scl_fall_ev),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .ptr_wr    (ptr_wr),
    .ptr_val   (ptr_val),
    .data_wr   (data_wr),
    .data_val  (data_val),
    .byte_pos  (byte_pos),
    .byte_done (byte_done_ev)
  );

  twfreq_regs #(.CTRL_INIT(CTRL_INIT), .RANGE_INIT(RANGE_INIT)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ptr_wr       (ptr_wr),
    .ptr_val      (ptr_val),
    .data_wr      (data_wr),
    .data_val     (data_val),
    .byte_pos     (byte_pos),
    .rd_data      (rd_data),
    .ctrl_commit  (ctrl_commit),
    .range_commit (range_commit),
    .ctrl_q       (ctrl_word),
    .range_q      (range_word)
  );
endmodule

// File: rtl/twfreq_regif_chk.sv
module twfreq_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic [9:0] ctrl_word,
  input logic [4:0] range_word,
  input logic       scl_s,
  input logic       scl_fall_ev,
  input logic       stop_ev,
  input logic       byte_done_ev,
  input logic       ctrl_commit,
  input logic       range_commit
);
  assert_ctrl_atomic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> $past(ctrl_commit));

  assert_range_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(range_word) |-> $past(range_commit));

  assert_drive_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> ($past(scl_fall_ev) && !scl_s));

  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  assert_commit_on_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_commit || range_commit) |-> byte_done_ev);
endmodule

bind twfreq_regif twfreq_regif_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sda_oe       (sda_oe),
  .ctrl_word    (ctrl_word),
  .range_word   (range_word),
  .scl_s        (scl_s),
  .scl_fall_ev  (scl_fall_ev),
  .stop_ev      (stop_ev),
  .byte_done_ev (byte_done_ev),
  .ctrl_commit  (ctrl_commit),
  .range_commit (range_commit)
);

// File: tb/twfreq_regif_tb.sv
module twfreq_regif_tb;
  localparam int Q = 8;
  localparam logic [7:0] WA = 8'hB0;
  localparam logic [7:0] RA = 8'hB1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [9:0] ctrl_word;
  logic [4:0] range_word;
  wire  sda_line = sda_m & ~sda_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [9:0] m_ctrl = 10'd500;
  logic [4:0] m_range = 5'd9;

  always #4 clk = ~clk;

  twfreq_regif u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .ctrl_word(ctrl_word), .range_word(range_word)
  );

  function automatic logic [7:0] hi_of(input logic [9:0] w); return w[9:2]; endfunction
  function automatic logic [7:0] lo_of(input logic [9:0] w); return {w[1:0], 6'b0}; endfunction
  function automatic logic [9:0] word_of(input logic [7:0] a, input logic [7:0] b);
    return {a, b[7:6]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    if (!scl) begin sda_m = 1'b1; hold(); scl = 1'b1; hold(); end
    else begin sda_m = 1'b1; hold(); end
    sda_m = 1'b0; hold();
    scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold();
      scl = 1'b1; hold(); hold();
      scl = 1'b0;
    end
    sda_m = 1'b1; hold();
    scl = 1'b1; hold();
    acked = ~sda_line;
    hold();
    scl = 1'b0; hold();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      scl = 1'b1; hold();
      b[i] = sda_line;
      hold();
      scl = 1'b0;
    end
    sda_m = ~give_ack; hold();
    scl = 1'b1; hold(); hold();
    scl = 1'b0; hold();
    sda_m = 1'b1;
  endtask

  task automatic write_two(input logic [7:0] idx, input logic [7:0] b0, input logic [7:0] b1);
    bit a;
    bus_start();
    send_byte(WA, a); chk(a, "R2 addr ack", a, 1);
    send_byte(idx, a); chk(a, "R3 index ack", a, 1);
    send_byte(b0, a); chk(a, "R4 data ack", a, 1);
    send_byte(b1, a); chk(a, "R8 data ack", a, 1);
    bus_stop();
  endtask

  task automatic read_two(input logic [7:0] idx, output logic [7:0] r0, output logic [7:0] r1);
    bit a;
    bus_start();
    send_byte(WA, a);
    send_byte(idx, a);
    bus_start();
    send_byte(RA, a); chk(a, "R2 read addr ack", a, 1);
    recv_byte(r0, 1'b1);
    recv_byte(r1, 1'b0);
    chk(sda_oe == 1'b0, "R10 release after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] r0, r1, r2;
    logic [9:0] w;
    logic [7:0] rb;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    chk(ctrl_word == 10'd500, "R1 ctrl reset", ctrl_word, 500);
    chk(range_word == 5'd9, "R1 range reset", range_word, 9);
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4/R5: tuning word write, output holds until second byte
    bus_start();
    send_byte(WA, a); chk(a, "R2 addr ack", a, 1);
    send_byte(8'h08, a); chk(a, "R3 ctrl index ack", a, 1);
    send_byte(8'hA9, a); chk(a, "R4 first byte ack", a, 1);
    chk(ctrl_word == m_ctrl, "R5 no half update", ctrl_word, m_ctrl);
    send_byte(8'h7F, a); chk(a, "R4 second byte ack", a, 1);
    bus_stop();
    m_ctrl = word_of(8'hA9, 8'h7F);
    chk(ctrl_word == m_ctrl, "R4 ctrl assembled", ctrl_word, m_ctrl);

    // R7: read back, including byte past width
    bus_start();
    send_byte(WA, a); send_byte(8'h08, a);
    bus_start();
    send_byte(RA, a);
    recv_byte(r0, 1'b1); recv_byte(r1, 1'b1); recv_byte(r2, 1'b0);
    bus_stop();
    chk(r0 == hi_of(m_ctrl), "R7 ctrl byte0", r0, hi_of(m_ctrl));
    chk(r1 == lo_of(m_ctrl), "R7 ctrl byte1", r1, lo_of(m_ctrl));
    chk(r2 == 8'h00, "R7 past width", r2, 0);
    chk(ctrl_word == m_ctrl, "R7 read no change", ctrl_word, m_ctrl);

    // R6: range write with upper bits set
    bus_start();
    send_byte(WA, a); send_byte(8'h0E, a);
    send_byte(8'hF3, a); chk(a, "R6 range ack", a, 1);
    bus_stop();
    m_range = 5'h13;
    chk(range_word == m_range, "R6 range low bits", range_word, m_range);

    // R5: single tuning byte then STOP
    bus_start();
    send_byte(WA, a); send_byte(8'h08, a); send_byte(8'h11, a);
    bus_stop();
    chk(ctrl_word == m_ctrl, "R5 single byte ignored", ctrl_word, m_ctrl);

    // R2: foreign address
    bus_start();
    send_byte(8'h46, a); chk(!a, "R2 foreign nack", a, 0);
    send_byte(8'h08, a); chk(!a, "R2 rest ignored", a, 0);
    send_byte(8'h00, a); send_byte(8'h00, a);
    bus_stop();
    chk(ctrl_word == m_ctrl, "R2 ctrl untouched", ctrl_word, m_ctrl);

    // R3: unknown index
    bus_start();
    send_byte(WA, a);
    send_byte(8'h09, a); chk(!a, "R3 unknown index nack", a, 0);
    send_byte(8'h55, a); chk(!a, "R3 data nack", a, 0);
    bus_stop();
    chk(ctrl_word == m_ctrl && range_word == m_range, "R3 regs untouched",
        {ctrl_word, range_word}, {m_ctrl, m_range});

    // R8: extra write bytes
    bus_start();
    send_byte(WA, a); send_byte(8'h08, a);
    send_byte(8'h3C, a); send_byte(8'h80, a);
    send_byte(8'hFF, a); chk(a, "R8 extra byte ack", a, 1);
    send_byte(8'h01, a); chk(a, "R8 extra byte ack 2", a, 1);
    bus_stop();
    m_ctrl = word_of(8'h3C, 8'h80);
    chk(ctrl_word == m_ctrl, "R8 extras discarded", ctrl_word, m_ctrl);

    // R9: repeated START mid-write, then pointer kept
    bus_start();
    send_byte(WA, a); send_byte(8'h08, a); send_byte(8'hEE, a);
    bus_start();
    send_byte(WA, a); send_byte(8'h0E, a); send_byte(8'h05, a);
    bus_stop();
    m_range = 5'h05;
    chk(ctrl_word == m_ctrl, "R9 restart drops half word", ctrl_word, m_ctrl);
    chk(range_word == m_range, "R9 restart new write", range_word, m_range);
    bus_start();
    send_byte(RA, a); chk(a, "R9 direct read ack", a, 1);
    recv_byte(rb, 1'b0);
    chk(sda_oe == 1'b0, "R10 released", sda_oe, 0);
    bus_stop();
    chk(rb == {3'b0, m_range}, "R9 pointer kept", rb, {3'b0, m_range});

    // random writes and reads
    for (int k = 0; k < 12; k++) begin
      w = 10'($urandom);
      write_two(8'h08, hi_of(w), {w[1:0], 6'($urandom)});
      m_ctrl = w;
      chk(ctrl_word == m_ctrl, "R4 random ctrl", ctrl_word, m_ctrl);
      read_two(8'h08, r0, r1);
      chk(r0 == hi_of(m_ctrl) && r1 == lo_of(m_ctrl), "R7 random readback",
          {r0, r1}, {hi_of(m_ctrl), lo_of(m_ctrl)});
      rb = 8'($urandom);
      bus_start();
      send_byte(WA, a); send_byte(8'h0E, a); send_byte(rb, a);
      bus_stop();
      m_range = rb[4:0];
      read_two(8'h0E, r0, r1);
      chk(r0 == {3'b0, m_range} && r1 == 8'h00, "R6 random range",
          {r0, r1}, {3'b0, m_range, 8'h00});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule